// File: doc/BRIEF.md
# Burst-of-Two Double-Rate SRAM Core with Write Forwarding

This block is a small synchronous memory with independent read and write request lines. Every operation moves a pair of words. A write carries one word on the rising edge of the primary clock phase (K) and a second word on the rising edge of the complementary phase (K#). The write address is taken from the shared address bus on the K# edge. A read takes its address from that bus on the K edge. Each data word has its own active-low byte mask.

A finished write sits in a pending register until the next write request pushes it into the array, or until a fixed drain delay has elapsed. A read that targets the pending address merges the pending bytes over the array contents byte by byte, so the newest data is always returned. The two phases come from one internal clock at twice the K rate. A phase register starts on K after reset and flips on every edge, and it is exported so that the driver knows which half it is in.

Top module: `burst2_sram`

## Requirements
- R1: While reset is held and just after it is released, `rvalid` is 0, `rdata` is 0, `k_phase` is 1 and every stored word reads back as zero.
- R2: `k_phase` inverts on every clock edge after reset. An edge at which it was 1 is a K edge and an edge at which it was 0 is a K# edge.
- R3: A K edge with `wr_n` low starts a write that takes `wdata`/`wmask_n` as word 0. The following K# edge supplies `addr` and `wdata`/`wmask_n` as word 1 of that write.
- R4: Mask bit i controls bits 8i+7..8i. A 0 stores that byte, and a 1 leaves the old byte unchanged. Each word of a pair uses its own mask.
- R5: A K edge with `rd_n` low reads the pair at `addr`. Word 0 appears on `rdata` during the clock cycle after that edge and word 1 during the cycle after that, with `rvalid` 1 in both. After a K edge without a read, `rvalid` is 0 for the next two cycles.
- R6: A read on the K edge right after a write's K# edge, to the same address, returns the written words.
- R7: When that read hits a write with some bytes masked, the masked bytes come from the older stored data and the enabled bytes from the new write.
- R8: Writes may start on consecutive K edges. A read on the same K edge as a new write request still sees the previous write, and every write of a back-to-back chain is kept.
- R9: `wr_n` and `rd_n` are ignored on K# edges. They start no operation and change no stored data.
- R10: A read on the same K edge that a write request starts returns the data as it was before that write.
- R11: A write followed by no further write request still becomes permanent, and reads after any idle gap return it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock; edges alternate K and K# |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Active-low write request, sampled on K edges |
| rd_n | input | 1 | Active-low read request, sampled on K edges |
| addr | input | AW | Read address on K edges, write address on K# edges |
| wdata | input | NB*8 | Write word, sampled on both phases of a write |
| wmask_n | input | NB | Active-low byte enables for the word in `wdata` |
| rdata | output | NB*8 | Read word 0 then word 1 |
| rvalid | output | 1 | High while `rdata` carries a read word |
| k_phase | output | 1 | 1 when the next edge is a K edge |

## Verification
The hardest case is a read that arrives in the one K edge where an older pending write is being pushed into the array by a new write request, while yet another write is half captured. Only the merge of the pre-edge array and the pending register gives the right answer there. The stimulus table reaches this point by placing a read and a new write in the same K cycle directly after an unfinished write. It then follows with a partly masked write that overwrites committed data, so that the byte merge is exercised against array contents rather than zeros.

// File: rtl/burst2_pkg.sv
package burst2_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic {
        PH_KB = 1'b0,
        PH_K  = 1'b1
    } phase_e;
endpackage

// File: rtl/burst2_wr_path.sv
module burst2_wr_path #(
    parameter int AW    = 4,
    parameter int NB    = 4,
    parameter int DRAIN = 6,
    localparam int DW   = NB * burst2_pkg::BYTE_W,
    localparam int CW   = $clog2(DRAIN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          k_edge,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [NB-1:0] wmask_n,
    output logic          pend_valid,
    output logic [AW-1:0] pend_addr,
    output logic [DW-1:0] pend_d0,
    output logic [DW-1:0] pend_d1,
    output logic [NB-1:0] pend_m0,
    output logic [NB-1:0] pend_m1,
    output logic          commit
);
    logic          stg_active;
    logic [DW-1:0] stg_d0;
    logic [NB-1:0] stg_m0;
    logic [CW-1:0] age;

    // The pending pair goes to the array when a new write starts or when it has aged out.
    assign commit = pend_valid &&
                    ((k_edge && !wr_n) || (age == CW'(DRAIN - 1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_active <= 1'b0;
            stg_d0     <= '0;
            stg_m0     <= '1;
            pend_valid <= 1'b0;
            pend_addr  <= '0;
            pend_d0    <= '0;
            pend_d1    <= '0;
            pend_m0    <= '1;
            pend_m1    <= '1;
            age        <= '0;
        end else begin
            if (k_edge) begin
                stg_active <= !wr_n;
                if (!wr_n) begin
                    stg_d0 <= wdata;
                    stg_m0 <= wmask_n;
                end
            end else begin
                stg_active <= 1'b0;
            end

            if (commit) begin
                pend_valid <= 1'b0;
                age        <= '0;
            end else if (pend_valid) begin
                age <= age + 1'b1;
            end

            if (!k_edge && stg_active) begin
                pend_valid <= 1'b1;
                pend_addr  <= addr;
                pend_d0    <= stg_d0;
                pend_m0    <= stg_m0;
                pend_d1    <= wdata;
                pend_m1    <= wmask_n;
                age        <= '0;
            end
        end
    end
endmodule

// File: rtl/burst2_store.sv
module burst2_store #(
    parameter int AW    = 4,
    parameter int NB    = 4,
    localparam int BW   = burst2_pkg::BYTE_W,
    localparam int DW   = NB * BW,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          commit,
    input  logic          fwd_valid,
    input  logic [AW-1:0] fwd_addr,
    input  logic [DW-1:0] fwd_d0,
    input  logic [DW-1:0] fwd_d1,
    input  logic [NB-1:0] fwd_m0,
    input  logic [NB-1:0] fwd_m1,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_w0,
    output logic [DW-1:0] rd_w1
);
    logic [DW-1:0] mem0 [DEPTH];
    logic [DW-1:0] mem1 [DEPTH];
    logic          hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem0[i] <= '0;
                mem1[i] <= '0;
            end
        end else if (commit) begin
            for (int b = 0; b < NB; b++) begin
                if (!fwd_m0[b]) mem0[fwd_addr][b*BW +: BW] <= fwd_d0[b*BW +: BW];
                if (!fwd_m1[b]) mem1[fwd_addr][b*BW +: BW] <= fwd_d1[b*BW +: BW];
            end
        end
    end

    assign hit = fwd_valid && (fwd_addr == rd_addr);

    // Per-lane selection between the pending register and the array.
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign rd_w0[g*BW +: BW] = (hit && !fwd_m0[g]) ? fwd_d0[g*BW +: BW]
                                                       : mem0[rd_addr][g*BW +: BW];
        assign rd_w1[g*BW +: BW] = (hit && !fwd_m1[g]) ? fwd_d1[g*BW +: BW]
                                                       : mem1[rd_addr][g*BW +: BW];
    end
endmodule

// File: rtl/burst2_rd_out.sv
module burst2_rd_out #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          k_edge,
    input  logic          rd_n,
    input  logic [DW-1:0] w0,
    input  logic [DW-1:0] w1,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    logic [DW-1:0] second;
    logic          second_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata    <= '0;
            rvalid   <= 1'b0;
            second   <= '0;
            second_v <= 1'b0;
        end else if (k_edge) begin
            rvalid   <= !rd_n;
            second_v <= !rd_n;
            rdata    <= rd_n ? '0 : w0;
            second   <= w1;
        end else begin
            rvalid   <= second_v;
            rdata    <= second_v ? second : '0;
            second_v <= 1'b0;
        end
    end
endmodule

// File: rtl/burst2_sram.sv
module burst2_sram #(
    parameter int AW    = 4,
    parameter int NB    = 4,
    parameter int DRAIN = 6,
    localparam int DW   = NB * burst2_pkg::BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [NB-1:0] wmask_n,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic          k_phase
);
    import burst2_pkg::*;

    phase_e        phase;
    logic          k_edge;
    logic          pend_valid;
    logic [AW-1:0] pend_addr;
    logic [DW-1:0] pend_d0, pend_d1;
    logic [NB-1:0] pend_m0, pend_m1;
    logic          commit;
    logic [DW-1:0] rd_w0, rd_w1;

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_K;
        else     phase <= (phase == PH_K) ? PH_KB : PH_K;
    end

    assign k_edge  = (phase == PH_K);
    assign k_phase = k_edge;

    burst2_wr_path #(.AW(AW), .NB(NB), .DRAIN(DRAIN)) u_wr (
        .clk(clk), .rst(rst), .k_edge(k_edge), .wr_n(wr_n), .addr(addr),
        .wdata(wdata), .wmask_n(wmask_n), .pend_valid(pend_valid),
        .pend_addr(pend_addr), .pend_d0(pend_d0), .pend_d1(pend_d1),
        .pend_m0(pend_m0), .pend_m1(pend_m1), .commit(commit)
    );

    burst2_store #(.AW(AW), .NB(NB)) u_store (
        .clk(clk), .rst(rst), .commit(commit), .fwd_valid(pend_valid),
        .fwd_addr(pend_addr), .fwd_d0(pend_d0), .fwd_d1(pend_d1),
        .fwd_m0(pend_m0), .fwd_m1(pend_m1), .rd_addr(addr),
        .rd_w0(rd_w0), .rd_w1(rd_w1)
    );

    burst2_rd_out #(.DW(DW)) u_rd (
        .clk(clk), .rst(rst), .k_edge(k_edge), .rd_n(rd_n),
        .w0(rd_w0), .w1(rd_w1), .rdata(rdata), .rvalid(rvalid)
    );
endmodule

// File: rtl/burst2_sram_chk.sv
module burst2_sram_chk #(
    parameter int DRAIN = 6,
    localparam int CCW  = $clog2(DRAIN + 2) + 1
) (
    input logic clk,
    input logic rst,
    input logic k_phase,
    input logic wr_n,
    input logic rd_n,
    input logic rvalid,
    input logic pend_valid
);
    logic [CCW-1:0] held;

    always_ff @(posedge clk) begin
        if (rst)             held <= '0;
        else if (pend_valid) held <= held + 1'b1;
        else                 held <= '0;
    end

    assert_phase_alt_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (k_phase != $past(k_phase)));

    assert_read_two_beats_R5: assert property (@(posedge clk) disable iff (rst)
        (k_phase && !rd_n) |=> rvalid ##1 rvalid);

    assert_idle_no_valid_R5: assert property (@(posedge clk) disable iff (rst)
        (k_phase && rd_n) |=> !rvalid);

    assert_kb_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        !k_phase |=> (rvalid == $past(rvalid)));

    assert_pending_loaded_R3: assert property (@(posedge clk) disable iff (rst)
        (k_phase && !wr_n) |=> ##1 pend_valid);

    assert_older_write_pushed_R8: assert property (@(posedge clk) disable iff (rst)
        (k_phase && !wr_n && pend_valid) |=> !pend_valid);

    assert_drain_bound_R11: assert property (@(posedge clk) disable iff (rst)
        held <= CCW'(DRAIN));
endmodule

bind burst2_sram burst2_sram_chk #(.DRAIN(DRAIN)) u_chk (
    .clk(clk), .rst(rst), .k_phase(k_phase), .wr_n(wr_n), .rd_n(rd_n),
    .rvalid(rvalid), .pend_valid(pend_valid)
);

// File: tb/sim_burst2_sram.sv
module sim_burst2_sram;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_n = 1'b1;
    logic        rd_n = 1'b1;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  wmask_n = 4'hF;
    logic [31:0] rdata;
    logic        rvalid;
    logic        k_phase;

    int errors = 0;
    int checks = 0;
    logic [31:0] g0, g1;
    logic        gv0, gv1;

    always #4 clk = ~clk;

    burst2_sram #(.AW(4), .NB(4), .DRAIN(6)) u0 (
        .clk(clk), .rst(rst), .wr_n(wr_n), .rd_n(rd_n), .addr(addr),
        .wdata(wdata), .wmask_n(wmask_n), .rdata(rdata), .rvalid(rvalid),
        .k_phase(k_phase)
    );

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [3:0]  ra;
        logic [3:0]  wa;
        logic [31:0] d0;
        logic [3:0]  m0;
        logic [31:0] d1;
        logic [3:0]  m1;
        logic [31:0] e0;
        logic [31:0] e1;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VT [NV] = '{
        '{1'b1, 1'b0, 4'd0, 4'd1, 32'h11110000, 4'h0, 32'h22220001, 4'h0, 32'h0, 32'h0},
        '{1'b1, 1'b1, 4'd1, 4'd2, 32'h33330002, 4'h0, 32'h44440003, 4'h0, 32'h11110000, 32'h22220001},
        '{1'b0, 1'b1, 4'd2, 4'd0, 32'h0, 4'hF, 32'h0, 4'hF, 32'h33330002, 32'h44440003},
        '{1'b1, 1'b0, 4'd0, 4'd1, 32'hAABBCCDD, 4'hA, 32'h55667788, 4'h5, 32'h0, 32'h0},
        '{1'b0, 1'b1, 4'd1, 4'd0, 32'h0, 4'hF, 32'h0, 4'hF, 32'h11BB00DD, 32'h55227701},
        '{1'b1, 1'b1, 4'd3, 4'd3, 32'hDEADBEEF, 4'h0, 32'hCAFEF00D, 4'h0, 32'h0, 32'h0},
        '{1'b0, 1'b1, 4'd3, 4'd0, 32'h0, 4'hF, 32'h0, 4'hF, 32'hDEADBEEF, 32'hCAFEF00D}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One K period: K-edge inputs, then K#-edge inputs; captures both result words.
    task automatic kcyc(input logic wr, input logic rd, input logic [3:0] ra,
                        input logic [31:0] d0, input logic [3:0] m0,
                        input logic [3:0] wa, input logic [31:0] d1,
                        input logic [3:0] m1, input logic kb_strobe);
        wr_n = !wr; rd_n = !rd; addr = ra; wdata = d0; wmask_n = m0;
        @(posedge clk);
        @(negedge clk);
        g0 = rdata; gv0 = rvalid;
        wr_n = !kb_strobe; rd_n = !kb_strobe; addr = wa; wdata = d1; wmask_n = m1;
        @(posedge clk);
        @(negedge clk);
        g1 = rdata; gv1 = rvalid;
        wr_n = 1'b1; rd_n = 1'b1; wmask_n = 4'hF;
    endtask

    task automatic rd_pair(input string req, input logic [3:0] a,
                           input logic [31:0] e0, input logic [31:0] e1);
        kcyc(1'b0, 1'b1, a, 32'h0, 4'hF, 4'd0, 32'h0, 4'hF, 1'b0);
        chk(req, {31'b0, gv0}, 32'd1);
        chk(req, g0, e0);
        chk(req, {31'b0, gv1}, 32'd1);
        chk(req, g1, e1);
    endtask

    task automatic wr_pair(input logic [3:0] a, input logic [31:0] d0, input logic [31:0] d1);
        kcyc(1'b1, 1'b0, 4'd0, d0, 4'h0, a, d1, 4'h0, 1'b0);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", {31'b0, rvalid}, 32'd0);
        chk("R1", rdata, 32'h0);
        chk("R1", {31'b0, k_phase}, 32'd1);
        rst = 1'b0;

        // R2: phase flips every edge
        for (int i = 0; i < 4; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R2", {31'b0, k_phase}, (i % 2 == 0) ? 32'd0 : 32'd1);
        end

        rd_pair("R1", 4'd9, 32'h0, 32'h0);

        // Table: R3/R6 forwarding, R8 read with commit, R4/R7 masked merge, R10 same-edge read
        for (int i = 0; i < NV; i++) begin
            kcyc(VT[i].wr, VT[i].rd, VT[i].ra, VT[i].d0, VT[i].m0,
                 VT[i].wa, VT[i].d1, VT[i].m1, 1'b0);
            if (VT[i].rd) begin
                chk("R3 R6 R7 R8 R10", {31'b0, gv0}, 32'd1);
                chk("R3 R6 R7 R8 R10", g0, VT[i].e0);
                chk("R3 R6 R7 R8 R10", {31'b0, gv1}, 32'd1);
                chk("R3 R6 R7 R8 R10", g1, VT[i].e1);
            end else begin
                chk("R5", {31'b0, gv0}, 32'd0);
                chk("R5", {31'b0, gv1}, 32'd0);
            end
        end

        // R9: strobes on K# only do nothing
        kcyc(1'b0, 1'b0, 4'd1, 32'h0, 4'h0, 4'd1, 32'hFFFFFFFF, 4'h0, 1'b1);
        chk("R9", {31'b0, gv0}, 32'd0);
        chk("R9", {31'b0, gv1}, 32'd0);
        kcyc(1'b0, 1'b0, 4'd1, 32'h0, 4'h0, 4'd1, 32'hFFFFFFFF, 4'h0, 1'b0);
        chk("R9", {31'b0, gv0}, 32'd0);
        rd_pair("R9", 4'd1, 32'h11BB00DD, 32'h55227701);

        // R8: back-to-back write chain
        wr_pair(4'd4, 32'h40404040, 32'h41414141);
        wr_pair(4'd5, 32'h50505050, 32'h51515151);
        wr_pair(4'd6, 32'h60606060, 32'h61616161);
        rd_pair("R8", 4'd4, 32'h40404040, 32'h41414141);
        rd_pair("R8", 4'd5, 32'h50505050, 32'h51515151);
        rd_pair("R8", 4'd6, 32'h60606060, 32'h61616161);

        // R11: lone write survives an idle gap
        wr_pair(4'd7, 32'h77777777, 32'h88888888);
        for (int i = 0; i < 8; i++)
            kcyc(1'b0, 1'b0, 4'd0, 32'h0, 4'hF, 4'd0, 32'h0, 4'hF, 1'b0);
        rd_pair("R11", 4'd7, 32'h77777777, 32'h88888888);
        rd_pair("R11", 4'd3, 32'hDEADBEEF, 32'hCAFEF00D);

        // R4: masked write over committed data, with the array as the only source
        kcyc(1'b1, 1'b0, 4'd0, 32'h99999999, 4'hE, 4'd7, 32'h12345678, 4'h7, 1'b0);
        for (int i = 0; i < 8; i++)
            kcyc(1'b0, 1'b0, 4'd0, 32'h0, 4'hF, 4'd0, 32'h0, 4'hF, 1'b0);
        rd_pair("R4", 4'd7, 32'h77777799, 32'h12888888);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule